// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date in packed BCD. A prescaled pulse (`sub_tick`) drives a sub-second divider; every `TICKS_PER_SEC` pulses the divider advances the clock by one second. Seconds, minutes and hours carry into the calendar part, which keeps day of week, date, month and a two-digit year. Month lengths and February of leap years are handled. The hours byte carries its own format bit, so software can pick a 12-hour or a 24-hour clock per write.

A write port loads any field at any time. A write to seconds also restarts the sub-second divider, so the next second begins at the moment of the write. A snapshot request copies all seven live fields into a holding buffer in one cycle. The read port then returns bytes from that buffer, so a multi-byte read sees one consistent instant while the live counters keep running.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields are seconds 0x00, minutes 0x00, hours 0x00 (24-hour midnight), day of week 0x01, date 0x01, month 0x01, year 0x00. The field selects are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year.
- R2: Seconds and minutes count in BCD from 0x00 to 0x59. At 0x59 they wrap to 0x00 and carry into the next field.
- R3: With hours bit 6 at 0 (24-hour format), bits 5:0 count from BCD 00 to 23. Bit 5 is the tens-of-hours bit for 20 to 23. Hour 23 wraps to 00 and carries into the day.
- R4: With hours bit 6 at 1 (12-hour format), bit 5 is the PM flag (1 = PM) and bits 4:0 count BCD 01 to 12. The order is 11 to 12 with the flag toggled, then 12 to 01 with the flag kept. Only the change from 11 PM to 12 AM carries into the day.
- R5: The date wraps to 01 after the last day of its month: 30 for months 04, 06, 09 and 11, and 31 for the other months other than February. The month runs 01 to 12 and then wraps to 01 with a year carry. The year runs 00 to 99 and then wraps to 00.
- R6: February has 29 days when the year value is divisible by 4 (00 counts as a leap year). Otherwise it has 28 days.
- R7: Day of week runs 01 to 07, then wraps to 01. It advances at midnight, in the same second as the date.
- R8: Bits that no field defines are dropped on write and read as 0. The kept bits are 0x7F for seconds, minutes and hours, 0x07 for day of week, 0x3F for date, 0x1F for month and 0xFF for year.
- R9: A write to seconds clears the sub-second divider. The next advance then comes exactly `TICKS_PER_SEC` `sub_tick` pulses after the write.
- R10: A write to any field other than seconds leaves the divider phase unchanged.
- R11: `snap_req` copies all seven fields into the read buffer at that clock edge. `rd_data` shows buffer byte `rd_sel` combinationally, and the buffer holds its value until the next `snap_req`. The select value 7 reads 0x00.
- R12: The live fields change only on a write, or on the `sub_tick` pulse that completes a count of `TICKS_PER_SEC` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle prescaled pulse feeding the sub-second divider |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for a write (0 to 6) |
| wr_data | input | 8 | Packed BCD value to write |
| snap_req | input | 1 | Copy all live fields into the read buffer |
| rd_sel | input | 3 | Buffer byte select for a read |
| rd_data | output | 8 | Selected buffer byte |

## Verification
The directed tests target the carries one at a time. They cover 23:59:59 on the last day of a year, the February end in a leap year and in a common year, a 30-day month, and the three 12-hour edges (11 AM, 11 PM and 12 PM). Each of these fails in its own way if a single rollover rule is wrong. Random legal start times are biased towards 59 and towards the end of the month, and each is advanced for one to three seconds. These runs show whether the chained carries agree with a bench model built on decimal arithmetic. Further tests check the divider phase after a seconds write and after a write to another field. Stale reads, taken without a new snapshot while time moves on, show that the buffer is separate from the live counters.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int FIELD_N = 7;
   localparam int SEL_W   = 3;

   localparam logic [SEL_W-1:0] F_SEC  = 3'd0;
   localparam logic [SEL_W-1:0] F_MIN  = 3'd1;
   localparam logic [SEL_W-1:0] F_HOUR = 3'd2;
   localparam logic [SEL_W-1:0] F_DOW  = 3'd3;
   localparam logic [SEL_W-1:0] F_DATE = 3'd4;
   localparam logic [SEL_W-1:0] F_MON  = 3'd5;
   localparam logic [SEL_W-1:0] F_YEAR = 3'd6;

   // bits kept per field on write
   function automatic logic [7:0] field_mask(input logic [SEL_W-1:0] sel);
      case (sel)
         F_SEC, F_MIN, F_HOUR: return 8'h7F;
         F_DOW:                return 8'h07;
         F_DATE:               return 8'h3F;
         F_MON:                return 8'h1F;
         F_YEAR:               return 8'hFF;
         default:              return 8'h00;
      endcase
   endfunction

   // next packed BCD value, no wrap
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic bcd_leap(input logic [7:0] y);
      logic [7:0] bin;
      bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
      return (bin[1:0] == 2'b00);
   endfunction

   // last date of a month, in BCD
   function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
   parameter int TICKS_PER_SEC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sub_tick,
   input  logic wr_sec,
   output logic adv
);

   initial begin
      if (TICKS_PER_SEC < 1) $error("TICKS_PER_SEC must be at least 1");
   end

   generate
      if (TICKS_PER_SEC == 1) begin : g_direct
         assign adv = sub_tick;
      end else begin : g_count
         localparam int DIV_W = $clog2(TICKS_PER_SEC);
         localparam logic [DIV_W-1:0] LAST = DIV_W'(TICKS_PER_SEC - 1);
         logic [DIV_W-1:0] cnt_q;

         assign adv = sub_tick && !wr_sec && (cnt_q == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n)            cnt_q <= '0;
            else if (wr_sec)       cnt_q <= '0;
            else if (sub_tick)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end

         p_cnt_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
         p_wr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_sec |=> cnt_q == '0);
         p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sec && !sub_tick |=> $stable(cnt_q));
      end
   endgenerate

endmodule

// File: rtl/cal_counters.sv
module cal_counters
   import cal_pkg::*;
#(
   parameter bit RESET_12H = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         adv,
   input  logic                         wr_en,
   input  logic [SEL_W-1:0]             wr_sel,
   input  logic [7:0]                   wr_data,
   output logic [FIELD_N-1:0][7:0]      live
);

   logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;
   logic [7:0] sec_n, min_n, hour_n, dow_n, date_n, mon_n, year_n;
   logic [7:0] hour_rst, hour_inc, wr_val;
   logic       c_min, c_hour, c_day, c_mon, c_year;

   generate
      if (RESET_12H) begin : g_rst12
         assign hour_rst = 8'h52;
      end else begin : g_rst24
         assign hour_rst = 8'h00;
      end
   endgenerate

   assign hour_inc = bcd_inc({2'b00, hour_q[5:0]});
   assign wr_val   = wr_data & field_mask(wr_sel);

   always_comb begin
      c_min  = (sec_q == 8'h59);
      sec_n  = c_min ? 8'h00 : bcd_inc(sec_q);
      c_hour = c_min && (min_q == 8'h59);
      min_n  = !c_min ? min_q : ((min_q == 8'h59) ? 8'h00 : bcd_inc(min_q));

      hour_n = hour_q;
      c_day  = 1'b0;
      if (c_hour) begin
         if (hour_q[6]) begin
            if (hour_q[4:0] == 5'h11) begin
               hour_n = {2'b01, ~hour_q[5], 5'h12};
               c_day  = hour_q[5];
            end else if (hour_q[4:0] == 5'h12) begin
               hour_n = {2'b01, hour_q[5], 5'h01};
            end else begin
               hour_n = {2'b01, hour_q[5], hour_inc[4:0]};
            end
         end else if (hour_q[5:0] == 6'h23) begin
            hour_n = 8'h00;
            c_day  = 1'b1;
         end else begin
            hour_n = {2'b00, hour_inc[5:0]};
         end
      end

      dow_n  = !c_day ? dow_q : ((dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01);
      c_mon  = c_day && (date_q == month_last(mon_q, year_q));
      date_n = !c_day ? date_q : (c_mon ? 8'h01 : bcd_inc(date_q));
      c_year = c_mon && (mon_q == 8'h12);
      mon_n  = !c_mon ? mon_q : (c_year ? 8'h01 : bcd_inc(mon_q));
      year_n = !c_year ? year_q : ((year_q == 8'h99) ? 8'h00 : bcd_inc(year_q));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q  <= 8'h00;
         min_q  <= 8'h00;
         hour_q <= hour_rst;
         dow_q  <= 8'h01;
         date_q <= 8'h01;
         mon_q  <= 8'h01;
         year_q <= 8'h00;
      end else begin
         if (adv) begin
            sec_q  <= sec_n;
            min_q  <= min_n;
            hour_q <= hour_n;
            dow_q  <= dow_n;
            date_q <= date_n;
            mon_q  <= mon_n;
            year_q <= year_n;
         end
         if (wr_en) begin
            case (wr_sel)
               F_SEC:   sec_q  <= wr_val;
               F_MIN:   min_q  <= wr_val;
               F_HOUR:  hour_q <= wr_val;
               F_DOW:   dow_q  <= wr_val;
               F_DATE:  date_q <= wr_val;
               F_MON:   mon_q  <= wr_val;
               F_YEAR:  year_q <= wr_val;
               default: ;
            endcase
         end
      end
   end

   assign live = {year_q, mon_q, date_q, dow_q, hour_q, min_q, sec_q};

   p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !wr_en && sec_q == 8'h59 |=> sec_q == 8'h00);
   p_quiet_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !adv && !wr_en |=> $stable(live));
   p_pm_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !wr_en && hour_q[6] && hour_q[4:0] == 5'h11 && min_q == 8'h59 && sec_q == 8'h59
      |=> hour_q[5] != $past(hour_q[5]));
   p_dow_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dow_q != 8'h00 && dow_q <= 8'h07);
   p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_q[7] && !min_q[7] && !hour_q[7] && date_q[7:6] == 2'b00 && mon_q[7:5] == 3'b000);

endmodule

// File: rtl/cal_snapshot.sv
module cal_snapshot
   import cal_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     snap_req,
   input  logic [FIELD_N-1:0][7:0]  live,
   input  logic [SEL_W-1:0]         rd_sel,
   output logic [7:0]               rd_data
);

   logic [FIELD_N-1:0][7:0] snap_q;

   generate
      for (genvar f = 0; f < FIELD_N; f++) begin : g_field
         always_ff @(posedge clk) begin
            if (!rst_n)        snap_q[f] <= 8'h00;
            else if (snap_req) snap_q[f] <= live[f];
         end
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      for (int f = 0; f < FIELD_N; f++) begin
         if (rd_sel == SEL_W'(f)) rd_data = snap_q[f];
      end
   end

   p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req |=> $stable(snap_q));
   p_snap_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> snap_q == $past(live));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import cal_pkg::*;
#(
   parameter int TICKS_PER_SEC = 8,
   parameter bit RESET_12H     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sub_tick,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [7:0]       wr_data,
   input  logic             snap_req,
   input  logic [2:0]       rd_sel,
   output logic [7:0]       rd_data
);

   logic                    adv;
   logic                    wr_sec;
   logic [FIELD_N-1:0][7:0] live;

   assign wr_sec = wr_en && (wr_sel == F_SEC);

   cal_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .sub_tick (sub_tick),
      .wr_sec   (wr_sec),
      .adv      (adv)
   );

   cal_counters #(.RESET_12H(RESET_12H)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .live    (live)
   );

   cal_snapshot i_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .snap_req (snap_req),
      .live     (live),
      .rd_sel   (rd_sel),
      .rd_data  (rd_data)
   );

endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;

   localparam int CLK_PERIOD = 10;
   localparam int TPS        = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sub_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic       snap_req = 1'b0;
   logic [2:0] rd_sel = 3'd0;
   logic [7:0] rd_data;

   int n_checks = 0;
   int n_fail   = 0;
   logic [7:0] mdl [7];
   logic [7:0] got [7];

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_calendar #(.TICKS_PER_SEC(TPS)) i_bcd_calendar (
      .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .snap_req(snap_req),
      .rd_sel(rd_sel), .rd_data(rd_data)
   );

   function automatic int b2i(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int days_in(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic model_step();
      int s, m, h, d, mo, y, dw;
      bit pm, next_day;
      s = b2i(mdl[0]); m = b2i(mdl[1]);
      next_day = 1'b0;
      s++;
      if (s == 60) begin
         s = 0; m++;
         if (m == 60) begin
            m = 0;
            if (mdl[2][6]) begin
               h = b2i({3'b000, mdl[2][4:0]}); pm = mdl[2][5];
               if (h == 11) begin h = 12; next_day = pm; pm = !pm; end
               else if (h == 12) h = 1;
               else h++;
               mdl[2] = {2'b01, pm, 5'(i2b(h))};
            end else begin
               h = b2i({2'b00, mdl[2][5:0]}) + 1;
               if (h == 24) begin h = 0; next_day = 1'b1; end
               mdl[2] = i2b(h);
            end
         end
      end
      mdl[0] = i2b(s); mdl[1] = i2b(m);
      if (next_day) begin
         dw = int'(mdl[3]); dw = (dw == 7) ? 1 : dw + 1; mdl[3] = 8'(dw);
         d = b2i(mdl[4]); mo = b2i(mdl[5]); y = b2i(mdl[6]);
         d++;
         if (d > days_in(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
         end
         mdl[4] = i2b(d); mdl[5] = i2b(mo); mdl[6] = i2b(y);
      end
   endtask

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic pulse_sub();
      @(negedge clk); sub_tick = 1'b1;
      @(negedge clk); sub_tick = 1'b0;
   endtask

   task automatic one_second();
      repeat (TPS) pulse_sub();
      model_step();
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                       input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                       input logic [7:0] y);
      wr(3'd1, m); wr(3'd2, h); wr(3'd3, dw); wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, y);
      wr(3'd0, s);
      mdl[0] = s; mdl[1] = m; mdl[2] = h; mdl[3] = dw; mdl[4] = dt; mdl[5] = mo; mdl[6] = y;
   endtask

   task automatic read_buf();
      for (int i = 0; i < 7; i++) begin
         @(negedge clk); rd_sel = 3'(i); #1 got[i] = rd_data;
      end
   endtask

   task automatic snap_read();
      @(negedge clk); snap_req = 1'b1;
      @(negedge clk); snap_req = 1'b0;
      read_buf();
   endtask

   task automatic cmp_all(input string tag);
      snap_read();
      for (int i = 0; i < 7; i++)
         chk(got[i] == mdl[i], $sformatf("%s field %0d", tag, i), got[i], mdl[i]);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] hold [7];
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      mdl[0] = 8'h00; mdl[1] = 8'h00; mdl[2] = 8'h00; mdl[3] = 8'h01;
      mdl[4] = 8'h01; mdl[5] = 8'h01; mdl[6] = 8'h00;
      cmp_all("R1 reset");

      // R2 R3 R5 R7: year end in 24-hour format
      load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      one_second();
      cmp_all("R2 R3 R5 R7 year end");
      chk(got[3] == 8'h01, "R7 dow wrap", got[3], 8'h01);
      chk(got[6] == 8'h00, "R5 year wrap", got[6], 8'h00);

      // R6 common year and leap year February
      load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
      one_second(); cmp_all("R6 common Feb");
      load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
      one_second(); cmp_all("R6 leap Feb 29");
      chk(got[4] == 8'h29, "R6 leap date", got[4], 8'h29);
      load(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h00);
      one_second(); cmp_all("R6 leap year 00 Mar 1");

      // R5 30-day month
      load(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h51);
      one_second(); cmp_all("R5 April end");

      // R4 12-hour edges
      load(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h06, 8'h10);
      one_second(); cmp_all("R4 11PM to 12AM");
      chk(got[2] == 8'h52, "R4 12AM code", got[2], 8'h52);
      load(8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h06, 8'h10);
      one_second(); cmp_all("R4 11AM to 12PM");
      chk(got[2] == 8'h72, "R4 12PM code", got[2], 8'h72);
      load(8'h59, 8'h59, 8'h72, 8'h03, 8'h15, 8'h06, 8'h10);
      one_second(); cmp_all("R4 12PM to 1PM");

      // R8 undefined bits dropped
      wr(3'd0, 8'hD5); wr(3'd1, 8'hB2); wr(3'd2, 8'hA3); wr(3'd3, 8'hFB);
      wr(3'd4, 8'hE5); wr(3'd5, 8'hF1); wr(3'd6, 8'h47);
      mdl[0] = 8'h55; mdl[1] = 8'h32; mdl[2] = 8'h23; mdl[3] = 8'h03;
      mdl[4] = 8'h25; mdl[5] = 8'h11; mdl[6] = 8'h47;
      cmp_all("R8 masked write");
      @(negedge clk); rd_sel = 3'd7; #1
      chk(rd_data == 8'h00, "R11 select 7", rd_data, 8'h00);

      // R9 seconds write restarts divider
      load(8'h05, 8'h10, 8'h08, 8'h02, 8'h10, 8'h03, 8'h20);
      repeat (TPS - 1) pulse_sub();
      wr(3'd0, 8'h10); mdl[0] = 8'h10;
      repeat (TPS - 1) pulse_sub();
      cmp_all("R9 no advance before full count");
      pulse_sub(); model_step();
      cmp_all("R9 advance after full count");

      // R10 other write keeps phase; R12 no advance early
      repeat (TPS - 1) pulse_sub();
      wr(3'd1, 8'h44); mdl[1] = 8'h44;
      cmp_all("R12 held before last pulse");
      pulse_sub(); model_step();
      cmp_all("R10 phase kept after minute write");

      // R11 buffer holds while time runs
      snap_read();
      for (int i = 0; i < 7; i++) hold[i] = got[i];
      one_second(); one_second();
      read_buf();
      for (int i = 0; i < 7; i++)
         chk(got[i] == hold[i], $sformatf("R11 stale field %0d", i), got[i], hold[i]);
      cmp_all("R11 fresh snapshot");

      // random legal starts, biased to carries
      for (int it = 0; it < 40; it++) begin
         int mo, y, d, h, n;
         bit pm, m12;
         logic [7:0] hb;
         mo = 1 + int'($urandom % 12);
         y  = int'($urandom % 100);
         d  = ($urandom % 2) ? days_in(mo, y) : 1 + int'($urandom % days_in(mo, y));
         m12 = $urandom % 2;
         if (m12) begin
            h = ($urandom % 2) ? 11 : 1 + int'($urandom % 12);
            pm = $urandom % 2;
            hb = {2'b01, pm, 5'(i2b(h))};
         end else begin
            h = ($urandom % 2) ? 23 : int'($urandom % 24);
            hb = i2b(h);
         end
         load(($urandom % 2) ? 8'h59 : i2b(int'($urandom % 60)),
              ($urandom % 2) ? 8'h59 : i2b(int'($urandom % 60)),
              hb, 8'(1 + $urandom % 7), i2b(d), i2b(mo), i2b(y));
         n = 1 + int'($urandom % 3);
         for (int k = 0; k < n; k++) one_second();
         cmp_all($sformatf("R2 R3 R4 R5 R6 R7 random %0d", it));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule